// File: doc/BRIEF.md
# FIFO Stall Watchdog and Interrupt Status

This block supervises the two data queues of an audio serial port, one feeding the transmitter and one filled by the receiver. A shared prescaler turns the core clock into slow ticks. While a direction is running but its queue shows no push or pop, that direction's stall counter advances once per tick. When the count reaches a programmable limit, the block raises one "hung" event for that direction.

The hung events sit beside the two transfer-complete pulses in a four-source interrupt unit. The unit holds a sticky raw status word, an enable word, a masked status word and a write-one-to-clear port, and it drives one combined interrupt line. The surrounding logic supplies activity strobes, done pulses and register writes. The block reads back its status words.

Top module: `fifo_stall_wd`

## Requirements
- R1: After reset, the raw, enable and masked status words are all zero, irq_o is low and stall detection is off.
- R2: A done pulse sets its raw bit on the next clock edge whether or not that bit is enabled. Bit positions are rx done = 0, tx done = 1, rx hung = 2, tx hung = 3. Bits 31:4 of every status word read zero.
- R3: The masked status word equals raw AND enable. irq_o is high exactly when some masked bit is set.
- R4: A clear write sets to zero each raw bit written as 1 and leaves bits written as 0 unchanged.
- R5: If an event and a clear of the same bit fall in one cycle, the event wins and the raw bit stays set.
- R6: The config write word is laid out as limit = bits 7:0, scale = bits 10:8 and enable = bit 11. While detection is enabled, the prescaler counts from 0 up to (88000 >> scale) inclusive and emits one tick on each wrap, so the tick period is (88000 >> scale) + 1 cycles.
- R7: A direction raises its hung event when its stall count equals the limit. The count advances on ticks only while that direction is active and has no activity. A limit of 0 fires as soon as an active direction stalls.
- R8: An activity strobe returns the stall count to zero. After firing, a stalled direction raises no further event until activity occurs.
- R9: While detection is disabled, no hung event is produced and the stall counters and prescaler stay at zero.
- R10: A direction that is not active never raises a hung event.
- R11: The two directions count independently. Activity on one direction does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the watchdog config word |
| cfg_wdata_i | input | 12 | Config word: limit 7:0, scale 10:8, enable 11 |
| ena_we_i | input | 1 | Write strobe for the interrupt enable word |
| ena_wdata_i | input | 4 | New interrupt enable bits |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear |
| clr_wdata_i | input | 4 | Raw bits to clear |
| rx_active_i | input | 1 | Receive direction is running |
| rx_activity_i | input | 1 | Receive queue pushed or popped this cycle |
| tx_active_i | input | 1 | Transmit direction is running |
| tx_activity_i | input | 1 | Transmit queue pushed or popped this cycle |
| rx_done_i | input | 1 | Receive transfer complete pulse |
| tx_done_i | input | 1 | Transmit transfer complete pulse |
| int_raw_o | output | 32 | Sticky raw status |
| int_ena_o | output | 32 | Interrupt enable readback |
| int_st_o | output | 32 | Masked status |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A corrupted stall counter or prescaler phase shows up only as a hung bit that appears too early, too late, twice, or not at all. The bench therefore samples the raw word in windows placed just before and just after the expected tick count, for two scale settings and three limits. A wrong raw or enable register shows up on the status words and irq_o on the very next cycle. Those paths are checked one cycle after each pulse or write, including the cycle where an event and a clear collide.

// File: rtl/fifo_wd_pkg.sv
package fifo_wd_pkg;

    localparam int unsigned IRQ_W       = 4;
    localparam int unsigned BIT_RX_DONE = 0;
    localparam int unsigned BIT_TX_DONE = 1;
    localparam int unsigned BIT_RX_HUNG = 2;
    localparam int unsigned BIT_TX_HUNG = 3;

    localparam int unsigned LIMIT_W = 8;
    localparam int unsigned SCALE_W = 3;
    localparam int unsigned CFG_W   = LIMIT_W + SCALE_W + 1;

    localparam int unsigned DIRS   = 2;
    localparam int unsigned DIR_RX = 0;
    localparam int unsigned DIR_TX = 1;

    typedef struct packed {
        logic               en;
        logic [SCALE_W-1:0] scale;
        logic [LIMIT_W-1:0] limit;
    } wd_cfg_t;

endpackage

// File: rtl/fifo_wd_tick.sv
module fifo_wd_tick #(
    parameter int unsigned BASE_PERIOD = 88000,
    parameter int unsigned SCALE_W     = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);
    localparam int unsigned CNT_W = $clog2(BASE_PERIOD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t s_d, s_q;
    logic [31:0] wrap_full;
    logic [CNT_W-1:0] wrap;
    logic at_wrap;

    always_comb begin
        wrap_full = 32'(BASE_PERIOD) >> scale_i;
        wrap      = wrap_full[CNT_W-1:0];
        at_wrap   = (s_q.cnt >= wrap);
        tick_o    = en_i && at_wrap;
        s_d       = s_q;
        if (!en_i || at_wrap) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fifo_wd_stall.sv
module fifo_wd_stall #(
    parameter int unsigned LIMIT_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               active_i,
    input  logic               activity_i,
    input  logic               tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               hung_o
);
    typedef struct packed {
        logic [LIMIT_W-1:0] cnt;
        logic               fired;
    } stall_state_t;

    stall_state_t s_d, s_q;

    always_comb begin
        hung_o = en_i && active_i && !activity_i
                 && (s_q.cnt == limit_i) && !s_q.fired;
        s_d = s_q;
        if (!en_i || activity_i) begin
            s_d.cnt   = '0;
            s_d.fired = 1'b0;
        end else begin
            if (hung_o) begin
                s_d.fired = 1'b1;
            end
            if (tick_i && active_i && (s_q.cnt < limit_i)) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fifo_wd_irq.sv
module fifo_wd_irq #(
    parameter int unsigned IRQ_W  = 4,
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IRQ_W-1:0]  evt_i,
    input  logic              ena_we_i,
    input  logic [IRQ_W-1:0]  ena_wdata_i,
    input  logic              clr_we_i,
    input  logic [IRQ_W-1:0]  clr_wdata_i,
    output logic [STAT_W-1:0] raw_o,
    output logic [STAT_W-1:0] ena_o,
    output logic [STAT_W-1:0] st_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] ena;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [IRQ_W-1:0] clr_mask;
    logic [IRQ_W-1:0] masked;

    always_comb begin
        clr_mask = clr_we_i ? clr_wdata_i : '0;
        s_d      = s_q;
        s_d.raw  = (s_q.raw & ~clr_mask) | evt_i;
        if (ena_we_i) begin
            s_d.ena = ena_wdata_i;
        end
        masked = s_q.raw & s_q.ena;
        raw_o  = STAT_W'(s_q.raw);
        ena_o  = STAT_W'(s_q.ena);
        st_o   = STAT_W'(masked);
        irq_o  = |masked;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fifo_stall_wd.sv
module fifo_stall_wd
    import fifo_wd_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = 88000,
    parameter int unsigned STAT_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [11:0]       cfg_wdata_i,
    input  logic              ena_we_i,
    input  logic [3:0]        ena_wdata_i,
    input  logic              clr_we_i,
    input  logic [3:0]        clr_wdata_i,
    input  logic              rx_active_i,
    input  logic              rx_activity_i,
    input  logic              tx_active_i,
    input  logic              tx_activity_i,
    input  logic              rx_done_i,
    input  logic              tx_done_i,
    output logic [STAT_W-1:0] int_raw_o,
    output logic [STAT_W-1:0] int_ena_o,
    output logic [STAT_W-1:0] int_st_o,
    output logic              irq_o
);
    wd_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d = wd_cfg_t'(cfg_wdata_i[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic tick;

    fifo_wd_tick #(
        .BASE_PERIOD (BASE_PERIOD),
        .SCALE_W     (SCALE_W)
    ) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (cfg_q.en),
        .scale_i (cfg_q.scale),
        .tick_o  (tick)
    );

    logic [DIRS-1:0] dir_active;
    logic [DIRS-1:0] dir_activity;
    logic [DIRS-1:0] dir_hung;

    assign dir_active[DIR_RX]   = rx_active_i;
    assign dir_active[DIR_TX]   = tx_active_i;
    assign dir_activity[DIR_RX] = rx_activity_i;
    assign dir_activity[DIR_TX] = tx_activity_i;

    for (genvar g = 0; g < DIRS; g++) begin : g_dir
        fifo_wd_stall #(
            .LIMIT_W (LIMIT_W)
        ) u_stall (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (cfg_q.en),
            .active_i   (dir_active[g]),
            .activity_i (dir_activity[g]),
            .tick_i     (tick),
            .limit_i    (cfg_q.limit),
            .hung_o     (dir_hung[g])
        );
    end

    logic [IRQ_W-1:0] evt;

    always_comb begin
        evt              = '0;
        evt[BIT_RX_DONE] = rx_done_i;
        evt[BIT_TX_DONE] = tx_done_i;
        evt[BIT_RX_HUNG] = dir_hung[DIR_RX];
        evt[BIT_TX_HUNG] = dir_hung[DIR_TX];
    end

    fifo_wd_irq #(
        .IRQ_W  (IRQ_W),
        .STAT_W (STAT_W)
    ) u_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt),
        .ena_we_i    (ena_we_i),
        .ena_wdata_i (ena_wdata_i),
        .clr_we_i    (clr_we_i),
        .clr_wdata_i (clr_wdata_i),
        .raw_o       (int_raw_o),
        .ena_o       (int_ena_o),
        .st_o        (int_st_o),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/fifo_wd_chk.sv
module fifo_wd_chk #(
    parameter int unsigned STAT_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              det_en,
    input logic              ena_we_i,
    input logic [3:0]        ena_wdata_i,
    input logic              clr_we_i,
    input logic [3:0]        clr_wdata_i,
    input logic              tx_activity_i,
    input logic              rx_done_i,
    input logic              tx_done_i,
    input logic [STAT_W-1:0] int_raw_o,
    input logic              irq_o
);
    assert_done_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_i |=> int_raw_o[0]);

    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && clr_wdata_i[0] && !rx_done_i) |=> !int_raw_o[0]);

    assert_evt_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && clr_wdata_i[1] && tx_done_i) |=> int_raw_o[1]);

    assert_mask_off_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ena_we_i && ena_wdata_i == 4'h0) |=> !irq_o);

    assert_no_hung_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !det_en |=> !$rose(int_raw_o[3]) && !$rose(int_raw_o[2]));

    assert_activity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_activity_i |=> !$rose(int_raw_o[3]));
endmodule

bind fifo_stall_wd fifo_wd_chk #(.STAT_W(STAT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .det_en        (cfg_q.en),
    .ena_we_i      (ena_we_i),
    .ena_wdata_i   (ena_wdata_i),
    .clr_we_i      (clr_we_i),
    .clr_wdata_i   (clr_wdata_i),
    .tx_activity_i (tx_activity_i),
    .rx_done_i     (rx_done_i),
    .tx_done_i     (tx_done_i),
    .int_raw_o     (int_raw_o),
    .irq_o         (irq_o)
);

// File: tb/fifo_stall_wd_tb.sv
module fifo_stall_wd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        ena_we = 1'b0;
    logic [3:0]  ena_wdata = '0;
    logic        clr_we = 1'b0;
    logic [3:0]  clr_wdata = '0;
    logic        rx_active = 1'b0, rx_activity = 1'b0;
    logic        tx_active = 1'b0, tx_activity = 1'b0;
    logic        rx_done = 1'b0, tx_done = 1'b0;
    logic [31:0] raw, ena, st;
    logic        irq;

    always #10 clk = ~clk;

    fifo_stall_wd dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .ena_we_i(ena_we), .ena_wdata_i(ena_wdata),
        .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
        .rx_active_i(rx_active), .rx_activity_i(rx_activity),
        .tx_active_i(tx_active), .tx_activity_i(tx_activity),
        .rx_done_i(rx_done), .tx_done_i(tx_done),
        .int_raw_o(raw), .int_ena_o(ena), .int_st_o(st), .irq_o(irq)
    );

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int n_checks = 0;
    int n_fail   = 0;

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                0: act = raw;
                1: act = ena;
                2: act = st;
                default: act = {31'd0, irq};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_val(string tag, int sel, logic [31:0] v);
        sb.push_back('{tag, sel, v});
    endtask

    task automatic wcfg(logic en, logic [2:0] sc, logic [7:0] lim);
        cfg_we = 1'b1; cfg_wdata = {en, sc, lim};
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic wena(logic [3:0] v);
        ena_we = 1'b1; ena_wdata = v;
        step(1);
        ena_we = 1'b0;
    endtask

    task automatic wclr(logic [3:0] v);
        clr_we = 1'b1; clr_wdata = v;
        step(1);
        clr_we = 1'b0;
    endtask

    bit done_flag = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_val("R1 raw", 0, 32'h0);
        expect_val("R1 ena", 1, 32'h0);
        expect_val("R1 st", 2, 32'h0);
        expect_val("R1 irq", 3, 32'h0);
        step(1);

        // R2: raw latches while disabled
        rx_done = 1'b1; step(1); rx_done = 1'b0;
        expect_val("R2 raw rx done", 0, 32'h1);
        expect_val("R3 st masked off", 2, 32'h0);
        expect_val("R3 irq off", 3, 32'h0);
        step(1);

        wena(4'hF);
        expect_val("R3 ena readback", 1, 32'hF);
        expect_val("R3 st", 2, 32'h1);
        expect_val("R3 irq on", 3, 32'h1);
        step(1);

        wena(4'h2);
        expect_val("R3 st other bit", 2, 32'h0);
        expect_val("R3 irq other bit", 3, 32'h0);
        step(1);

        tx_done = 1'b1; step(1); tx_done = 1'b0;
        expect_val("R2 raw tx done", 0, 32'h3);
        expect_val("R3 st tx", 2, 32'h2);
        expect_val("R3 irq tx", 3, 32'h1);
        step(1);

        wclr(4'h1);
        expect_val("R4 clear one bit", 0, 32'h2);
        step(1);

        // R5: event and clear collide
        tx_done = 1'b1; clr_we = 1'b1; clr_wdata = 4'h2;
        step(1);
        tx_done = 1'b0; clr_we = 1'b0;
        expect_val("R5 event wins", 0, 32'h2);
        step(1);
        wclr(4'h2);
        expect_val("R4 clear tx", 0, 32'h0);
        step(1);
        wena(4'hF);

        // R7: tx stalls, limit 2, scale 7 -> period 688
        tx_active = 1'b1; rx_active = 1'b0;
        wcfg(1'b1, 3'd7, 8'd2);
        step(1300);
        expect_val("R7 tx not yet hung", 0, 32'h0);
        step(150);
        expect_val("R7 tx hung, R10 rx idle", 0, 32'h8);
        expect_val("R3 irq hung", 3, 32'h1);
        step(1);

        // R8: one event per stall
        wclr(4'h8);
        step(3000);
        expect_val("R8 no second event", 0, 32'h0);
        step(1);

        // R8: activity restarts
        tx_activity = 1'b1; step(1); tx_activity = 1'b0;
        step(680);
        expect_val("R8 restart early", 0, 32'h0);
        step(720);
        expect_val("R8 restart fired", 0, 32'h8);
        step(1);
        wclr(4'h8);

        // R11: rx with periodic activity then stall
        wcfg(1'b0, 3'd7, 8'd2);
        tx_active = 1'b0; rx_active = 1'b1;
        wcfg(1'b1, 3'd7, 8'd2);
        for (int i = 0; i < 8; i++) begin
            step(400);
            rx_activity = 1'b1; step(1); rx_activity = 1'b0;
        end
        expect_val("R8 activity keeps rx quiet", 0, 32'h0);
        step(1450);
        expect_val("R11 rx hung alone", 0, 32'h4);
        step(1);
        wclr(4'h4);

        // R9: detection disabled
        wcfg(1'b0, 3'd7, 8'd2);
        tx_active = 1'b1; rx_active = 1'b1;
        step(4000);
        expect_val("R9 disabled no hung", 0, 32'h0);
        step(1);

        // R6: scale 7, limit 1 -> fires about 689 cycles after enable
        rx_active = 1'b0;
        wcfg(1'b1, 3'd7, 8'd1);
        step(600);
        expect_val("R6 scale7 early", 0, 32'h0);
        step(150);
        expect_val("R6 scale7 fired", 0, 32'h8);
        step(1);
        wcfg(1'b0, 3'd6, 8'd1);
        wclr(4'h8);
        wcfg(1'b1, 3'd6, 8'd1);
        step(1300);
        expect_val("R6 scale6 early", 0, 32'h0);
        step(150);
        expect_val("R6 scale6 fired", 0, 32'h8);
        step(1);

        // R7: limit zero fires at once
        wcfg(1'b0, 3'd7, 8'd0);
        wclr(4'h8);
        expect_val("R4 clear before limit0", 0, 32'h0);
        step(1);
        wcfg(1'b1, 3'd7, 8'd0);
        step(2);
        expect_val("R7 limit zero", 0, 32'h8);
        step(1);
        wena(4'h0);
        expect_val("R3 irq masked off", 3, 32'h0);
        expect_val("R3 st masked off", 2, 32'h0);
        step(2);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule